// File: doc/BRIEF.md
# Lane Address to Bank Mapper

This block sits in front of a multi-bank scratchpad used by a SIMD core. Every cycle it can take one byte address per lane and, for all lanes at once, work out which bank holds the addressed word and which line inside that bank it sits on. The byte-within-word bits are carried alongside for the byte-enable logic further down the pipe. Conflict detection and data steering live in later stages.

The mapping rule is held in a small configuration register that software-side control logic may rewrite between requests, with no reset in between. Three rules are offered. Interleaved mapping puts neighbouring words in neighbouring banks. Banked-linear mapping fills one bank before moving to the next. Skewed-interleave mapping adds a per-line rotation of `entry * c` to the interleaved bank, so that strided lanes land on a diagonal instead of piling into one bank. The factor c is programmed as a power of two or zero. The results are registered and appear one cycle after the request.

Top module: `lane_bank_mapper`

## Requirements
- R1: Results for all lanes are produced in parallel; `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and the fields then hold the mapping of that request.
- R2: With mode code 0 (interleaved) and word index w = addr >> 2, the bank is w mod B and the entry is w / B.
- R3: With mode code 1 (banked-linear), the bank is the top log2(B) bits of w and the entry is the low log2(D) bits of w.
- R4: With mode code 2 (skewed-interleave), the entry is w / B and the bank is (entry * c + w mod B) mod B.
- R5: The factor field k encodes c = 0 for k = 0 and c = 2^(k-1) for k >= 1 (k = 1..5 give c = 1, 2, 4, 8, 16); with c = 0 skewed mode gives the same bank as interleaved mode.
- R6: The low 2 address bits come out unchanged on the byte field of each lane and take no part in bank or entry selection.
- R7: A configuration write with mode code 3 is dropped as a whole: neither mode nor factor changes.
- R8: A request uses the configuration held before its cycle; a configuration write in the same cycle as a request takes effect from the next request, and the rule can be changed repeatedly without reset.
- R9: After reset the mode is interleaved with factor 0, `rsp_valid` is low and all result fields are zero.
- R10: In a cycle with no request the result fields keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode code: 0 interleaved, 1 banked-linear, 2 skewed, 3 reserved |
| cfg_factor | input | FACTOR_W | Skew factor code k |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | LANES*ADDR_W | Lane byte addresses, lane 0 in the low bits |
| rsp_valid | output | 1 | Results valid |
| rsp_bank | output | LANES*BANK_W | Bank index per lane |
| rsp_entry | output | LANES*ENTRY_W | In-bank word offset per lane |
| rsp_byte | output | LANES*BYTE_W | Byte-within-word bits per lane |

## Verification
The bench aims stride-by-B address groups at skewed mode with each factor code, where a missing or wrong shift would leave every lane on bank 0 or rotate by the wrong step, and at the large factors whose product wraps to zero mod B. It writes a configuration in the same cycle as a request, which catches a design that forwards the new rule too early, and it writes the reserved mode code, which a design lacking the filter would take as interleaved or garbage. Addresses that differ only in byte bits expose a bank selection that wrongly includes them, and idle cycles expose outputs that do not hold.

// File: rtl/lane_bank_map_pkg.sv
package lane_bank_map_pkg;

  localparam int MAP_FACTOR_W = 3;

  typedef enum logic [1:0] {
    MAP_INTERLEAVE = 2'd0,
    MAP_LINEAR     = 2'd1,
    MAP_SKEWED     = 2'd2
  } map_mode_e;

  localparam logic [1:0] MAP_RESERVED = 2'd3;

endpackage

// File: rtl/lane_bank_map_cfg.sv
module lane_bank_map_cfg
  import lane_bank_map_pkg::*;
#(
  parameter int FACTOR_W = MAP_FACTOR_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_mode,
  input  logic [FACTOR_W-1:0] wr_factor,
  output map_mode_e           mode_o,
  output logic [FACTOR_W-1:0] factor_o
);

  map_mode_e           mode_q;
  logic [FACTOR_W-1:0] factor_q;
  logic                accept;

  assign accept = wr_en && (wr_mode != MAP_RESERVED);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MAP_INTERLEAVE;
      factor_q <= '0;
    end else if (accept) begin
      mode_q   <= map_mode_e'(wr_mode);
      factor_q <= wr_factor;
    end
  end

  assign mode_o   = mode_q;
  assign factor_o = factor_q;

  // R7: the reserved code never reaches the held mode
  a_r7_no_reserved_mode: assert property (@(posedge clk) disable iff (rst)
    logic'(mode_q != map_mode_e'(MAP_RESERVED)));

  // R8: without a write strobe the held rule does not move
  a_r8_cfg_holds: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(mode_q) && $stable(factor_q)));

endmodule

// File: rtl/lane_bank_map_lane.sv
module lane_bank_map_lane
  import lane_bank_map_pkg::*;
#(
  parameter int BANK_W   = 3,
  parameter int ENTRY_W  = 6,
  parameter int BYTE_W   = 2,
  parameter int FACTOR_W = MAP_FACTOR_W
) (
  input  logic [BYTE_W+BANK_W+ENTRY_W-1:0] addr_i,
  input  map_mode_e                        mode_i,
  input  logic [FACTOR_W-1:0]              factor_i,
  output logic [BANK_W-1:0]                bank_o,
  output logic [ENTRY_W-1:0]               entry_o,
  output logic [BYTE_W-1:0]                byte_o
);

  localparam int WORD_W = BANK_W + ENTRY_W;
  localparam int ADDR_W = BYTE_W + WORD_W;

  logic [WORD_W-1:0]   word;
  logic [BANK_W-1:0]   ilv_bank;
  logic [ENTRY_W-1:0]  ilv_entry;
  logic [BANK_W-1:0]   lin_bank;
  logic [ENTRY_W-1:0]  lin_entry;
  logic [FACTOR_W-1:0] shamt;
  logic [ENTRY_W-1:0]  shifted;
  logic [BANK_W-1:0]   skew_term;
  logic [BANK_W-1:0]   skew_bank;

  assign word      = addr_i[ADDR_W-1:BYTE_W];
  assign byte_o    = addr_i[BYTE_W-1:0];

  // interleaved split: low bits pick the bank
  assign ilv_bank  = word[BANK_W-1:0];
  assign ilv_entry = word[WORD_W-1:BANK_W];

  // linear split: high bits pick the bank
  assign lin_bank  = word[WORD_W-1:ENTRY_W];
  assign lin_entry = word[ENTRY_W-1:0];

  // c = 2^(k-1): the product is a left shift, and mod B keeps the low bits
  always_comb begin
    shamt     = factor_i - FACTOR_W'(1);
    shifted   = ilv_entry << shamt;
    skew_term = (factor_i == '0) ? '0 : shifted[BANK_W-1:0];
    skew_bank = ilv_bank + skew_term;
  end

  always_comb begin
    unique case (mode_i)
      MAP_LINEAR: begin
        bank_o  = lin_bank;
        entry_o = lin_entry;
      end
      MAP_SKEWED: begin
        bank_o  = skew_bank;
        entry_o = ilv_entry;
      end
      default: begin
        bank_o  = ilv_bank;
        entry_o = ilv_entry;
      end
    endcase
  end

  // R5: a zero factor leaves the skewed bank equal to the interleaved bank
  always_comb begin
    if (mode_i == MAP_SKEWED && factor_i == '0)
      a_r5_zero_factor: assert (bank_o == addr_i[BYTE_W+BANK_W-1:BYTE_W]);
  end

endmodule

// File: rtl/lane_bank_mapper.sv
module lane_bank_mapper
  import lane_bank_map_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int BANK_W   = 3,
  parameter int ENTRY_W  = 6,
  parameter int BYTE_W   = 2,
  parameter int FACTOR_W = MAP_FACTOR_W
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   cfg_we,
  input  logic [1:0]                             cfg_mode,
  input  logic [FACTOR_W-1:0]                    cfg_factor,
  input  logic                                   req_valid,
  input  logic [LANES*(BYTE_W+BANK_W+ENTRY_W)-1:0] req_addr,
  output logic                                   rsp_valid,
  output logic [LANES*BANK_W-1:0]                rsp_bank,
  output logic [LANES*ENTRY_W-1:0]               rsp_entry,
  output logic [LANES*BYTE_W-1:0]                rsp_byte
);

  localparam int ADDR_W = BYTE_W + BANK_W + ENTRY_W;

  map_mode_e           cur_mode;
  logic [FACTOR_W-1:0] cur_factor;

  logic [LANES*BANK_W-1:0]  map_bank;
  logic [LANES*ENTRY_W-1:0] map_entry;
  logic [LANES*BYTE_W-1:0]  map_byte;
  logic [LANES*BYTE_W-1:0]  in_byte;

  lane_bank_map_cfg #(
    .FACTOR_W (FACTOR_W)
  ) cfg_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cfg_we),
    .wr_mode   (cfg_mode),
    .wr_factor (cfg_factor),
    .mode_o    (cur_mode),
    .factor_o  (cur_factor)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_bank_map_lane #(
      .BANK_W   (BANK_W),
      .ENTRY_W  (ENTRY_W),
      .BYTE_W   (BYTE_W),
      .FACTOR_W (FACTOR_W)
    ) lane_i (
      .addr_i   (req_addr[g*ADDR_W +: ADDR_W]),
      .mode_i   (cur_mode),
      .factor_i (cur_factor),
      .bank_o   (map_bank[g*BANK_W +: BANK_W]),
      .entry_o  (map_entry[g*ENTRY_W +: ENTRY_W]),
      .byte_o   (map_byte[g*BYTE_W +: BYTE_W])
    );
    assign in_byte[g*BYTE_W +: BYTE_W] = req_addr[g*ADDR_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_bank  <= '0;
      rsp_entry <= '0;
      rsp_byte  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_bank  <= map_bank;
        rsp_entry <= map_entry;
        rsp_byte  <= map_byte;
      end
    end
  end

  // R1: one response per request, one cycle later
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R6: byte bits reach the output untouched
  a_r6_byte_pass: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_byte == $past(in_byte)));

  // R10: idle cycles leave the result fields alone
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(rsp_bank) && $stable(rsp_entry) && $stable(rsp_byte)));

endmodule

// File: tb/lane_bank_mapper_tb_top.sv
`timescale 1ns/1ps
module lane_bank_mapper_tb_top;

  localparam int LANES = 4;
  localparam int BW    = 3;
  localparam int EW    = 6;
  localparam int YW    = 2;
  localparam int FW    = 3;
  localparam int AW    = YW + BW + EW;
  localparam int NB    = 1 << BW;
  localparam int ND    = 1 << EW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_mode = '0;
  logic [FW-1:0] cfg_factor = '0;
  logic req_valid = 1'b0;
  logic [LANES*AW-1:0] req_addr = '0;
  logic rsp_valid;
  logic [LANES*BW-1:0] rsp_bank;
  logic [LANES*EW-1:0] rsp_entry;
  logic [LANES*YW-1:0] rsp_byte;

  int checks = 0;
  int failures = 0;
  int m_mode = 0;
  int m_k = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  lane_bank_mapper dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_factor(cfg_factor), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_bank(rsp_bank), .rsp_entry(rsp_entry),
    .rsp_byte(rsp_byte)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_bank(input int a, input int mode, input int k);
    int w, c;
    w = a >> 2;
    c = (k == 0) ? 0 : (1 << (k - 1));
    if (mode == 1) return w / ND;
    if (mode == 2) return ((w / NB) * c + (w % NB)) % NB;
    return w % NB;
  endfunction

  function automatic int exp_entry(input int a, input int mode);
    int w;
    w = a >> 2;
    if (mode == 1) return w % ND;
    return w / NB;
  endfunction

  task automatic write_cfg(input int mode, input int k);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode = 2'(mode); cfg_factor = FW'(k);
    @(negedge clk);
    cfg_we = 1'b0;
    if (mode != 3) begin m_mode = mode; m_k = k; end
  endtask

  // drive one request and compare every lane against the model
  task automatic issue(input int a0, input int a1, input int a2, input int a3,
                       input string req);
    int a [LANES];
    a[0] = a0; a[1] = a1; a[2] = a2; a[3] = a3;
    @(negedge clk);
    for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = AW'(a[i]);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid (R1)"}, int'(rsp_valid), 1);
    for (int i = 0; i < LANES; i++) begin
      check({req, " bank"}, int'(rsp_bank[i*BW +: BW]), exp_bank(a[i], m_mode, m_k));
      check({req, " entry"}, int'(rsp_entry[i*EW +: EW]), exp_entry(a[i], m_mode));
      check({req, " byte (R6)"}, int'(rsp_byte[i*YW +: YW]), a[i] % 4);
    end
  endtask

  task automatic t_reset;
    check("R9 rsp_valid after reset", int'(rsp_valid), 0);
    check("R9 bank after reset", int'(rsp_bank), 0);
    check("R9 entry after reset", int'(rsp_entry), 0);
    issue(12'h024, 12'h104, 12'h3FC, 12'h7E8, "R9 default interleaved");
  endtask

  task automatic t_interleave;
    write_cfg(0, 0);
    issue(12'h000, 12'h004, 12'h01C, 12'h020, "R2 interleaved a");
    issue(12'h7FC, 12'h400, 12'h13C, 12'h2A8, "R2 interleaved b");
  endtask

  task automatic t_linear;
    write_cfg(1, 0);
    issue(12'h000, 12'h004, 12'h100, 12'h7FC, "R3 linear a");
    issue(12'h0FC, 12'h200, 12'h55C, 12'h3A0, "R3 linear b");
  endtask

  task automatic t_skew;
    for (int k = 1; k <= 5; k++) begin
      write_cfg(2, k);
      // stride of B words: same interleaved bank, successive entries
      issue(12'h000, 12'h020, 12'h040, 12'h060, "R4 R5 skew stride");
      issue(12'h7FC, 12'h1E4, 12'h33C, 12'h5A8, "R4 R5 skew mixed");
    end
  endtask

  task automatic t_skew_zero;
    write_cfg(2, 0);
    issue(12'h020, 12'h044, 12'h068, 12'h7FC, "R5 zero factor");
  endtask

  task automatic t_byte;
    write_cfg(2, 1);
    issue(12'h0A0, 12'h0A1, 12'h0A2, 12'h0A3, "R6 byte bits only");
    check("R6 same bank across byte bits", int'(rsp_bank[3*BW +: BW]), int'(rsp_bank[0 +: BW]));
  endtask

  task automatic t_reserved;
    write_cfg(1, 0);
    write_cfg(3, 2);
    issue(12'h020, 12'h104, 12'h6F0, 12'h044, "R7 reserved write dropped");
  endtask

  task automatic t_same_cycle;
    write_cfg(0, 0);
    @(negedge clk);
    req_addr = '0;
    req_addr[0 +: AW] = AW'(12'h020);
    req_addr[AW +: AW] = AW'(12'h040);
    req_valid = 1'b1; cfg_we = 1'b1; cfg_mode = 2'd2; cfg_factor = FW'(1);
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    check("R8 same-cycle write uses old rule lane0", int'(rsp_bank[0 +: BW]), 0);
    check("R8 same-cycle write uses old rule lane1", int'(rsp_bank[BW +: BW]), 0);
    m_mode = 2; m_k = 1;
    issue(12'h020, 12'h040, 12'h060, 12'h080, "R8 new rule next request");
    write_cfg(1, 0);
    issue(12'h020, 12'h40C, 12'h060, 12'h7F0, "R8 rule changed again");
  endtask

  task automatic t_hold;
    logic [LANES*BW-1:0] b;
    logic [LANES*EW-1:0] e;
    write_cfg(0, 0);
    issue(12'h1FC, 12'h0E4, 12'h2B8, 12'h350, "R10 setup");
    b = rsp_bank; e = rsp_entry;
    @(negedge clk);
    req_addr = '1;
    @(negedge clk);
    check("R1 no response when idle", int'(rsp_valid), 0);
    check("R10 bank held", int'(rsp_bank == b), 1);
    check("R10 entry held", int'(rsp_entry == e), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_interleave();
    t_linear();
    t_skew();
    t_skew_zero();
    t_byte();
    t_reserved();
    t_same_cycle();
    t_hold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule